// File: doc/BRIEF.md
# Unaligned Operand Access Splitter

This block takes one load or store that may start at any byte address and carries it out as a run of naturally aligned sub-accesses. It picks the piece size once, when it accepts the request. That size is the operand size or the alignment that the start address guarantees, whichever is smaller. The block then moves the whole operand in equal pieces of that size, at addresses that rise from the start address. For a store it cuts the operand into pieces. For a load it collects the returned pieces into one right-justified operand.

Two byte orders are supported. In native order, the piece at the lowest address holds the most significant end of the operand. In reversed order, the block swaps the order of the pieces itself and labels each sub-access with the mode. The storage side then only needs to handle the byte order inside one aligned piece. The splitter holds one request at a time and gives a response for every request. For a load the response carries the data, and for a store it carries zero.

Top module: `uas_splitter`

## Requirements
- R1: Sizes are coded as log2 of the byte count (0 = 8 bits up to 4 = 128 bits). The piece size code equals the number of trailing zero bits of the start address, capped at the operand size code. It is the same for every piece of one request.
- R2: A request is carried out as exactly 2^(operand code − piece code) sub-accesses. An operand whose address is aligned to its own size uses a single sub-access.
- R3: The first sub-access address equals the start address. Each later one is the previous address plus the piece size in bytes, so every sub-access is aligned to its own size.
- R4: In native mode a store sends, as piece i, operand bits counted from the most significant end: piece 0 carries the top slice.
- R5: In reversed mode a store sends, as piece i, operand bits counted from the least significant end: piece 0 carries the bottom slice.
- R6: In native mode a load places the data returned for piece i in the slice where R4 takes it from, and returns the operand right-justified in the response.
- R7: In reversed mode a load places the data returned for piece i in the slice where R5 takes it from.
- R8: Every sub-access carries the endian mode of its request on sub_rev, held for the whole request.
- R9: req_ready is high only when idle. It stays low from acceptance until the response has been taken with rsp_valid and rsp_ready both high, and rsp_valid stays high until then.
- R10: While sub_valid is high and sub_ready is low, the sub-access address, size and write data hold their values.
- R11: Store pieces are right-justified on sub_wdata, with all bits above the piece size zero. A load issues the next sub-access only after sub_rvalid has returned the previous piece.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to accept |
| req_addr | input | 12 | Operand start byte address |
| req_size | input | 3 | Operand size code (log2 bytes) |
| req_write | input | 1 | 1 = store, 0 = load |
| req_rev | input | 1 | 1 = reversed byte order |
| req_wdata | input | 128 | Store operand, right-justified |
| sub_valid | output | 1 | Sub-access offered |
| sub_ready | input | 1 | Sub-access taken |
| sub_addr | output | 12 | Aligned sub-access address |
| sub_size | output | 3 | Sub-access size code |
| sub_write | output | 1 | Sub-access is a store |
| sub_rev | output | 1 | Byte order for the storage side |
| sub_wdata | output | 128 | Store piece, right-justified |
| sub_rvalid | input | 1 | Load piece returned |
| sub_rdata | input | 128 | Returned piece, right-justified |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Response taken |
| rsp_data | output | 128 | Assembled load operand (zero for stores) |

## Verification
The bench sweeps every start offset from 0 to 15 for each operand size and both modes. It stores through the block into a byte-array model and then loads the operand back in both orders. Odd offsets force byte pieces and offsets of two or four force middle-sized pieces. A design that worked the piece size out from the wrong end of the address, or from the operand size alone, would give the wrong piece count or a misaligned address. If the piece order were swapped in the wrong mode, bytes would land in the wrong places in memory. If a load used the store slot numbering, it would return the operand with its halves or quarters scrambled. The bench also stalls sub_ready and rsp_ready at random. This catches a command that changes while stalled, or a request accepted before the response is taken.

// File: rtl/uas_pkg.sv
package uas_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_RESP
  } uas_state_e;
endpackage

// File: rtl/uas_plan.sv
// Chooses the piece size from the start address alignment and the operand size,
// and reports the index of the final piece.
module uas_plan #(
  parameter int MAX_LG = 4,
  parameter int SZ_W   = 3,
  parameter int CW     = 4
) (
  input  logic [MAX_LG-1:0] lo_addr,
  input  logic [SZ_W-1:0]   op_lg,
  output logic [SZ_W-1:0]   piece_lg,
  output logic [CW-1:0]     last_idx
);
  logic found;
  int   span;

  always_comb begin
    piece_lg = op_lg;
    found    = 1'b0;
    for (int b = 0; b < MAX_LG; b++) begin
      if (!found && lo_addr[b]) begin
        found = 1'b1;
        if (SZ_W'(b) < op_lg) piece_lg = SZ_W'(b);
      end
    end
    span     = int'(op_lg) - int'(piece_lg);
    last_idx = CW'((1 << span) - 1);
  end
endmodule

// File: rtl/uas_lane.sv
// Moves one piece between an operand slot and a right-justified bus.
// INSERT = 0 extracts slot -> bus, INSERT = 1 places bus -> slot.
module uas_lane #(
  parameter int MAX_LG = 4,
  parameter int SZ_W   = 3,
  parameter int CW     = 4,
  parameter bit INSERT = 1'b0,
  localparam int DW    = 8 << MAX_LG
) (
  input  logic [SZ_W-1:0] piece_lg,
  input  logic [CW-1:0]   slot,
  input  logic [DW-1:0]   din,
  output logic [DW-1:0]   dout
);
  int          shamt;
  int          pbits;
  logic [DW-1:0] mask;

  always_comb begin
    pbits = 8 << piece_lg;
    shamt = int'(slot) << (int'(piece_lg) + 3);
    mask  = ~({DW{1'b1}} << pbits);
  end

  generate
    if (INSERT) begin : g_place
      always_comb dout = (din & mask) << shamt;
    end else begin : g_take
      always_comb dout = (din >> shamt) & mask;
    end
  endgenerate
endmodule

// File: rtl/uas_splitter.sv
module uas_splitter
  import uas_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int MAX_LG = 4,
  localparam int DW    = 8 << MAX_LG,
  localparam int SZ_W  = $clog2(MAX_LG + 1),
  localparam int CW    = (MAX_LG < 1) ? 1 : MAX_LG
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SZ_W-1:0]   req_size,
  input  logic              req_write,
  input  logic              req_rev,
  input  logic [DW-1:0]     req_wdata,
  output logic              sub_valid,
  input  logic              sub_ready,
  output logic [ADDR_W-1:0] sub_addr,
  output logic [SZ_W-1:0]   sub_size,
  output logic              sub_write,
  output logic              sub_rev,
  output logic [DW-1:0]     sub_wdata,
  input  logic              sub_rvalid,
  input  logic [DW-1:0]     sub_rdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DW-1:0]     rsp_data
);
  uas_state_e      state_q;
  logic [SZ_W-1:0] size_q, pk_q;
  logic [CW-1:0]   last_q, idx_q;
  logic            wr_q, rev_q;
  logic [DW-1:0]   wdata_q, acc_q;

  // planning for a new request
  logic [SZ_W-1:0] plan_pk;
  logic [CW-1:0]   plan_last;

  uas_plan #(.MAX_LG(MAX_LG), .SZ_W(SZ_W), .CW(CW)) i_plan (
    .lo_addr (req_addr[MAX_LG-1:0]),
    .op_lg   (req_size),
    .piece_lg(plan_pk),
    .last_idx(plan_last)
  );

  logic            starting;
  logic [CW-1:0]   nxt_idx, nxt_slot, cur_slot, cur_last;
  logic [SZ_W-1:0] cur_pk;
  logic            cur_rev;
  logic [DW-1:0]   cur_src, nxt_piece, placed, acc_n;
  logic [ADDR_W-1:0] nxt_addr;

  assign req_ready = (state_q == ST_IDLE);
  assign starting  = req_valid && req_ready;

  always_comb begin
    nxt_idx  = starting ? '0 : idx_q + CW'(1);
    cur_pk   = starting ? plan_pk : pk_q;
    cur_last = starting ? plan_last : last_q;
    cur_rev  = starting ? req_rev : rev_q;
    cur_src  = starting ? req_wdata : wdata_q;
    nxt_slot = cur_rev ? nxt_idx : cur_last - nxt_idx;
    cur_slot = rev_q ? idx_q : last_q - idx_q;
    nxt_addr = sub_addr + (ADDR_W'(1) << pk_q);
    acc_n    = acc_q | placed;
  end

  // slot -> bus for stores
  uas_lane #(.MAX_LG(MAX_LG), .SZ_W(SZ_W), .CW(CW), .INSERT(1'b0)) i_take (
    .piece_lg(cur_pk),
    .slot    (nxt_slot),
    .din     (cur_src),
    .dout    (nxt_piece)
  );

  // bus -> slot for loads
  uas_lane #(.MAX_LG(MAX_LG), .SZ_W(SZ_W), .CW(CW), .INSERT(1'b1)) i_place (
    .piece_lg(pk_q),
    .slot    (cur_slot),
    .din     (sub_rdata),
    .dout    (placed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      size_q    <= '0;
      pk_q      <= '0;
      last_q    <= '0;
      idx_q     <= '0;
      wr_q      <= 1'b0;
      rev_q     <= 1'b0;
      wdata_q   <= '0;
      acc_q     <= '0;
      sub_valid <= 1'b0;
      sub_addr  <= '0;
      sub_size  <= '0;
      sub_write <= 1'b0;
      sub_rev   <= 1'b0;
      sub_wdata <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            size_q    <= req_size;
            pk_q      <= plan_pk;
            last_q    <= plan_last;
            idx_q     <= '0;
            wr_q      <= req_write;
            rev_q     <= req_rev;
            wdata_q   <= req_wdata;
            acc_q     <= '0;
            sub_valid <= 1'b1;
            sub_addr  <= req_addr;
            sub_size  <= plan_pk;
            sub_write <= req_write;
            sub_rev   <= req_rev;
            sub_wdata <= req_write ? nxt_piece : '0;
            state_q   <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (sub_ready) begin
            if (wr_q) begin
              if (idx_q == last_q) begin
                sub_valid <= 1'b0;
                rsp_valid <= 1'b1;
                rsp_data  <= '0;
                state_q   <= ST_RESP;
              end else begin
                idx_q     <= nxt_idx;
                sub_addr  <= nxt_addr;
                sub_wdata <= nxt_piece;
              end
            end else begin
              sub_valid <= 1'b0;
              state_q   <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (sub_rvalid) begin
            if (idx_q == last_q) begin
              rsp_data  <= acc_n;
              rsp_valid <= 1'b1;
              state_q   <= ST_RESP;
            end else begin
              acc_q     <= acc_n;
              idx_q     <= nxt_idx;
              sub_addr  <= nxt_addr;
              sub_valid <= 1'b1;
              state_q   <= ST_ISSUE;
            end
          end
        end
        default: begin
          if (rsp_ready) begin
            rsp_valid <= 1'b0;
            state_q   <= ST_IDLE;
          end
        end
      endcase
    end
  end

  // pieces handed over since the current request was accepted
  logic [CW:0] issued_q;
  always_ff @(posedge clk) begin
    if (rst || starting) issued_q <= '0;
    else if (sub_valid && sub_ready) issued_q <= issued_q + (CW+1)'(1);
  end

  a_r1_piece_within_operand: assert property (@(posedge clk) disable iff (rst)
    sub_valid |-> sub_size <= size_q);

  a_r3_sub_aligned: assert property (@(posedge clk) disable iff (rst)
    sub_valid |-> ((sub_addr & ~({ADDR_W{1'b1}} << sub_size)) == '0));

  a_r2_piece_count: assert property (@(posedge clk) disable iff (rst)
    $rose(rsp_valid) |-> issued_q == ({1'b0, last_q} + (CW+1)'(1)));

  a_r9_busy_blocks_req: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid || sub_valid) |-> !req_ready);

  a_r9_rsp_held: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  a_r10_sub_held: assert property (@(posedge clk) disable iff (rst)
    sub_valid && !sub_ready |=> sub_valid && $stable(sub_addr) && $stable(sub_size)
                                && $stable(sub_wdata));
endmodule

// File: tb/test_uas_splitter.sv
module test_uas_splitter;
  localparam int ADDR_W = 12;
  localparam int MAX_LG = 4;
  localparam int DW     = 8 << MAX_LG;
  localparam int SZ_W   = 3;
  localparam int MEMSZ  = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic              req_valid = 1'b0, req_ready, req_write = 1'b0, req_rev = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [SZ_W-1:0]   req_size = '0;
  logic [DW-1:0]     req_wdata = '0;
  logic              sub_valid, sub_ready, sub_write, sub_rev, sub_rvalid;
  logic [ADDR_W-1:0] sub_addr;
  logic [SZ_W-1:0]   sub_size;
  logic [DW-1:0]     sub_wdata, sub_rdata;
  logic              rsp_valid, rsp_ready = 1'b0;
  logic [DW-1:0]     rsp_data;

  uas_splitter #(.ADDR_W(ADDR_W), .MAX_LG(MAX_LG)) i_uas_splitter (
    .clk, .rst, .req_valid, .req_ready, .req_addr, .req_size, .req_write, .req_rev,
    .req_wdata, .sub_valid, .sub_ready, .sub_addr, .sub_size, .sub_write, .sub_rev,
    .sub_wdata, .sub_rvalid, .sub_rdata, .rsp_valid, .rsp_ready, .rsp_data
  );

  // counters of the stimulus process and of the responder process
  int checks = 0, fails = 0;
  int r_checks = 0, r_fails = 0;
  bit done = 1'b0;

  // expectations published by the stimulus process
  int  op_id = 0;
  int  exp_start = 0, exp_pk = 0;
  bit  exp_rev = 1'b0;

  // storage model and responder state
  logic [7:0] mem [MEMSZ];
  int   fires_total = 0;
  int   seen_op = -1;
  int   prev_addr = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit   pend = 1'b0, held = 1'b0;
  logic [ADDR_W-1:0] c_addr, h_addr;
  logic [SZ_W-1:0]   c_size;
  logic              c_write, c_rev;
  logic [DW-1:0]     c_wdata, h_wdata;

  initial begin
    sub_ready  = 1'b0;
    sub_rvalid = 1'b0;
    sub_rdata  = '0;
    for (int i = 0; i < MEMSZ; i++) mem[i] = 8'h00;
  end

  always @(negedge clk) begin
    if (!rst) begin
      sub_rvalid = 1'b0;
      sub_rdata  = '0;
      if (pend) begin
        int pb;
        logic [DW-1:0] v;
        pb = 1 << int'(c_size);
        fires_total = fires_total + 1;
        r_checks = r_checks + 1;
        if (int'(c_size) != exp_pk) begin
          r_fails = r_fails + 1;
          $display("FAIL R1 piece size act=%0d exp=%0d", c_size, exp_pk);
        end
        r_checks = r_checks + 1;
        if ((seen_op != op_id && int'(c_addr) != exp_start) ||
            (seen_op == op_id && int'(c_addr) != prev_addr)) begin
          r_fails = r_fails + 1;
          $display("FAIL R3 sub address act=%0d exp=%0d", c_addr,
                   (seen_op != op_id) ? exp_start : prev_addr);
        end
        r_checks = r_checks + 1;
        if (c_rev != exp_rev) begin
          r_fails = r_fails + 1;
          $display("FAIL R8 sub_rev act=%0d exp=%0d", c_rev, exp_rev);
        end
        seen_op   = op_id;
        prev_addr = int'(c_addr) + pb;
        if (c_write) begin
          r_checks = r_checks + 1;
          if (pb < 16 && (c_wdata >> (8 * pb)) != '0) begin
            r_fails = r_fails + 1;
            $display("FAIL R11 upper store bits act=%h exp=0", c_wdata);
          end
          for (int k = 0; k < pb; k++)
            mem[(int'(c_addr) + k) % MEMSZ] =
              c_rev ? c_wdata[8*k +: 8] : c_wdata[8*(pb-1-k) +: 8];
        end else begin
          v = '0;
          for (int k = 0; k < pb; k++)
            v = v | (DW'(mem[(int'(c_addr) + k) % MEMSZ]) << (8 * (c_rev ? k : pb - 1 - k)));
          sub_rdata  = v;
          sub_rvalid = 1'b1;
        end
      end
      if (held) begin
        r_checks = r_checks + 1;
        if (!sub_valid || sub_addr != h_addr || sub_wdata != h_wdata) begin
          r_fails = r_fails + 1;
          $display("FAIL R10 stalled command changed act=%0d/%h exp=%0d/%h",
                   sub_addr, sub_wdata, h_addr, h_wdata);
        end
      end
      lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sub_ready = lfsr[0] | lfsr[3];
      pend      = sub_valid && sub_ready;
      held      = sub_valid && !sub_ready;
      c_addr = sub_addr; c_size = sub_size; c_write = sub_write;
      c_rev  = sub_rev;  c_wdata = sub_wdata;
      h_addr = sub_addr; h_wdata = sub_wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic int tz_cap(input int a, input int s);
    int r = 0;
    while (r < s && ((a >> r) & 1) == 0) r++;
    return r;
  endfunction

  task automatic run_op(input int a, input int s, input bit wr, input bit rv,
                        input logic [DW-1:0] wd, output logic [DW-1:0] rd,
                        output int npieces);
    int  f0;
    bit  busy_ok = 1'b1;
    op_id     = op_id + 1;
    exp_start = a;
    exp_pk    = tz_cap(a, s);
    exp_rev   = rv;
    f0        = fires_total;
    req_addr  = ADDR_W'(a);
    req_size  = SZ_W'(s);
    req_write = wr;
    req_rev   = rv;
    req_wdata = wd;
    req_valid = 1'b1;
    @(posedge clk); #2;
    req_valid = 1'b0;
    while (!rsp_valid) begin
      if (req_ready) busy_ok = 1'b0;
      @(posedge clk); #2;
    end
    rd = rsp_data;
    @(posedge clk); #2;
    chk(busy_ok && rsp_valid && !req_ready, "R9", "busy/response held",
        {rsp_valid, req_ready}, 2'b10);
    rsp_ready = 1'b1;
    @(posedge clk); #2;
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, "R9", "idle after response", {rsp_valid, req_ready}, 2'b01);
    @(negedge clk); #2;
    npieces = fires_total - f0;
  endtask

  initial begin
    logic [DW-1:0] v, rb, rd, exp_mem;
    int a, nb, np;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(posedge clk); #2;
    chk(req_ready && !sub_valid && !rsp_valid, "reset", "idle outputs",
        {req_ready, sub_valid, rsp_valid}, 3'b100);
    for (int rv = 0; rv < 2; rv++) begin
      for (int s = 0; s <= MAX_LG; s++) begin
        for (int off = 0; off < 16; off++) begin
          a  = 32 + off;
          nb = 1 << s;
          v  = '0;
          rb = '0;
          for (int k = 0; k < nb; k++)
            v[8*k +: 8] = 8'(k * 37 + off * 11 + s * 3 + rv * 101 + 1);
          for (int k = 0; k < nb; k++)
            rb[8*k +: 8] = v[8*(nb-1-k) +: 8];
          run_op(a, s, 1'b1, rv[0], v, rd, np);
          chk(np == (1 << (s - tz_cap(a, s))), "R2", "store piece count", DW'(np),
              DW'(1 << (s - tz_cap(a, s))));
          chk(rd == '0, "R9", "store response data", rd, '0);
          exp_mem = '0;
          rd      = '0;
          for (int k = 0; k < nb; k++) begin
            rd[8*k +: 8]      = mem[(a + k) % MEMSZ];
            exp_mem[8*k +: 8] = rv ? v[8*k +: 8] : v[8*(nb-1-k) +: 8];
          end
          chk(rd == exp_mem, rv ? "R5" : "R4", "stored bytes", rd, exp_mem);
          run_op(a, s, 1'b0, rv[0], '0, rd, np);
          chk(rd == v, rv ? "R7" : "R6", "load same order", rd, v);
          chk(np == (1 << (s - tz_cap(a, s))), "R11", "load piece count", DW'(np),
              DW'(1 << (s - tz_cap(a, s))));
          run_op(a, s, 1'b0, !rv[0], '0, rd, np);
          chk(rd == rb, rv ? "R6" : "R7", "load other order", rd, rb);
        end
      end
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", (checks + r_checks) - (fails + r_fails),
             checks + r_checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog act=running exp=finished");
      $display("%0d/%0d checks passed", (checks + r_checks) - (fails + r_fails),
               checks + r_checks + 1);
      $finish;
    end
  end
endmodule